// File: doc/BRIEF.md
# Dual-Port RAM with Selectable Write Output

A synchronous block RAM with two fully independent ports, A and B. Each port has its own clock, clock enable, write enable, address, write data and registered read data. Either port can read or write any word, so data written through one port can be fetched through the other.

What a port's output register shows on a write cycle is fixed per port by a parameter: it keeps its previous value (normal), it takes the data being written (write-through), or it takes the word's value from before the write (read-before-write). The last choice is only accepted at data widths of 9, 18 or 36 bits; any other pairing of mode and width stops elaboration with an error.

Each output register has an asynchronous active-high local reset, and a shared active-low global reset clears both. Resets act on the output registers only; the stored words are kept.

Top module: `tdp_ram_wm`

## Requirements
- R1: A read cycle (clock enable high, write enable low) loads the addressed word into the port's data output at that clock edge, one cycle after the address is presented.
- R2: In normal mode, a write cycle stores the data and leaves the port's data output unchanged.
- R3: In write-through mode, after a write cycle the port's data output equals the data just written.
- R4: In read-before-write mode, after a write cycle the port's data output equals the word's previous contents, and the new data is stored.
- R5: With clock enable low, a port neither writes memory nor changes its data output, whatever its write enable, address and data.
- R6: Raising the port A local reset clears the port A output to zero at once, without a clock edge, and leaves the port B output unchanged.
- R7: Raising the port B local reset clears the port B output to zero at once and leaves the port A output unchanged.
- R8: Driving the global reset low clears both port outputs to zero at once.
- R9: No reset changes the stored words; a read after any reset returns the data written before it.
- R10: A word written through one port is returned by a later read through the other port.
- R11: Read-before-write is legal only at data widths 9, 18 and 36; normal and write-through are legal at any width. The legality function returns 1 for a legal pair and 0 otherwise, and an illegal parameter pair is an elaboration error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_a | input | 1 | Port A clock |
| rst_a | input | 1 | Port A asynchronous output reset, active high |
| en_a | input | 1 | Port A clock enable |
| we_a | input | 1 | Port A write enable |
| addr_a | input | ADDR_W | Port A word address |
| din_a | input | DATA_W | Port A write data |
| dout_a | output | DATA_W | Port A registered read data |
| clk_b | input | 1 | Port B clock |
| rst_b | input | 1 | Port B asynchronous output reset, active high |
| en_b | input | 1 | Port B clock enable |
| we_b | input | 1 | Port B write enable |
| addr_b | input | ADDR_W | Port B word address |
| din_b | input | DATA_W | Port B write data |
| dout_b | output | DATA_W | Port B registered read data |
| glob_rst_n | input | 1 | Global output reset for both ports, active low |

## Verification
The words are held as two banks whose XOR is the true value. A corrupt bank entry therefore shows as a wrong value on the first read of that address through either port, one clock edge after the read is presented. A wrong mode choice shows on the edge that ends a write: the output moves when it should hold, or shows new data where old data is expected. A reset wired to the wrong register shows without any clock edge, as the other port's output dropping to zero or this port's output staying put.

// File: rtl/tdp_ram_pkg.sv
package tdp_ram_pkg;

    // Output behaviour of a port on a write cycle
    typedef enum logic [1:0] {
        WM_NORMAL     = 2'd0,  // output holds
        WM_WRITE_THRU = 2'd1,  // output shows the incoming data
        WM_READ_OLD   = 2'd2   // output shows the word before the write
    } wr_mode_e;

    // What a port does on a clock edge
    typedef enum logic [1:0] {
        ACT_IDLE  = 2'd0,
        ACT_READ  = 2'd1,
        ACT_WRITE = 2'd2
    } port_act_e;

    // R11: read-before-write needs a 9, 18 or 36 bit word
    function automatic logic mode_ok(wr_mode_e mode, int unsigned width);
        if (mode != WM_READ_OLD) return 1'b1;
        return (width == 9) || (width == 18) || (width == 36);
    endfunction

    function automatic port_act_e port_action(logic en, logic we);
        if (!en) return ACT_IDLE;
        return we ? ACT_WRITE : ACT_READ;
    endfunction

endpackage

// File: rtl/tdp_xor_store.sv
// Two-clock storage built from two single-writer banks. The stored word is
// the XOR of both banks; a port writes its own bank with data ^ other bank.
module tdp_xor_store #(
    parameter int ADDR_W = 6,
    parameter int DATA_W = 9
) (
    input  logic [1:0]        clk_v,
    input  logic [1:0]        we_v,
    input  logic [ADDR_W-1:0] addr_v  [2],
    input  logic [DATA_W-1:0] wdata_v [2],
    output logic [DATA_W-1:0] rdata_v [2]
);
    localparam int DEPTH = 1 << ADDR_W;
    localparam int NPORT = 2;

    // look[bank][port]: the bank's entry at the port's address
    logic [DATA_W-1:0] look [NPORT][NPORT];

    for (genvar b = 0; b < NPORT; b++) begin : g_bank
        localparam int OTHER = NPORT - 1 - b;
        logic [DATA_W-1:0] mem [DEPTH];

        for (genvar p = 0; p < NPORT; p++) begin : g_look
            assign look[b][p] = mem[addr_v[p]];
        end

        always_ff @(posedge clk_v[b]) begin
            if (we_v[b]) begin
                mem[addr_v[b]] <= wdata_v[b] ^ look[OTHER][b];
            end
        end
    end

    for (genvar p = 0; p < NPORT; p++) begin : g_rd
        assign rdata_v[p] = look[0][p] ^ look[1][p];
    end

endmodule

// File: rtl/tdp_port_out.sv
// Registered data output of one port with its write-cycle behaviour.
module tdp_port_out
    import tdp_ram_pkg::*;
#(
    parameter int       DATA_W = 9,
    parameter wr_mode_e MODE   = WM_NORMAL
) (
    input  logic              clk,
    input  logic              arst,
    input  logic              en,
    input  logic              we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] word_now,
    output logic [DATA_W-1:0] dout
);
    logic [DATA_W-1:0] wr_view;

    if (MODE == WM_WRITE_THRU) begin : g_thru
        assign wr_view = wdata;
    end else if (MODE == WM_READ_OLD) begin : g_old
        assign wr_view = word_now;
    end else begin : g_hold
        assign wr_view = dout;
    end

    always_ff @(posedge clk or posedge arst) begin
        if (arst) begin
            dout <= '0;
        end else begin
            case (port_action(en, we))
                ACT_READ:  dout <= word_now;
                ACT_WRITE: dout <= wr_view;
                default:   dout <= dout;
            endcase
        end
    end

endmodule

// File: rtl/tdp_ram_wm.sv
module tdp_ram_wm
    import tdp_ram_pkg::*;
#(
    parameter int       ADDR_W = 6,
    parameter int       DATA_W = 9,
    parameter wr_mode_e MODE_A = WM_READ_OLD,
    parameter wr_mode_e MODE_B = WM_WRITE_THRU
) (
    input  logic              clk_a,
    input  logic              rst_a,
    input  logic              en_a,
    input  logic              we_a,
    input  logic [ADDR_W-1:0] addr_a,
    input  logic [DATA_W-1:0] din_a,
    output logic [DATA_W-1:0] dout_a,
    input  logic              clk_b,
    input  logic              rst_b,
    input  logic              en_b,
    input  logic              we_b,
    input  logic [ADDR_W-1:0] addr_b,
    input  logic [DATA_W-1:0] din_b,
    output logic [DATA_W-1:0] dout_b,
    input  logic              glob_rst_n
);
    // R11: illegal mode/width pairs stop elaboration
    if (!mode_ok(MODE_A, DATA_W)) begin : g_bad_mode_a
        $error("port A: read-before-write needs a data width of 9, 18 or 36");
    end
    if (!mode_ok(MODE_B, DATA_W)) begin : g_bad_mode_b
        $error("port B: read-before-write needs a data width of 9, 18 or 36");
    end

    typedef struct packed {
        logic              en;
        logic              we;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } req_t;

    req_t              req_a, req_b;
    logic [1:0]        clk_v, we_v;
    logic [ADDR_W-1:0] addr_v  [2];
    logic [DATA_W-1:0] wdata_v [2];
    logic [DATA_W-1:0] rdata_v [2];
    logic              arst_a, arst_b;

    assign req_a = '{en: en_a, we: we_a, addr: addr_a, data: din_a};
    assign req_b = '{en: en_b, we: we_b, addr: addr_b, data: din_b};

    assign clk_v      = {clk_b, clk_a};
    assign we_v       = {req_b.en & req_b.we, req_a.en & req_a.we};
    assign addr_v[0]  = req_a.addr;
    assign addr_v[1]  = req_b.addr;
    assign wdata_v[0] = req_a.data;
    assign wdata_v[1] = req_b.data;

    assign arst_a = rst_a | ~glob_rst_n;
    assign arst_b = rst_b | ~glob_rst_n;

    tdp_xor_store #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_store (
        .clk_v   (clk_v),
        .we_v    (we_v),
        .addr_v  (addr_v),
        .wdata_v (wdata_v),
        .rdata_v (rdata_v)
    );

    tdp_port_out #(.DATA_W(DATA_W), .MODE(MODE_A)) u_out_a (
        .clk      (clk_a),
        .arst     (arst_a),
        .en       (req_a.en),
        .we       (req_a.we),
        .wdata    (req_a.data),
        .word_now (rdata_v[0]),
        .dout     (dout_a)
    );

    tdp_port_out #(.DATA_W(DATA_W), .MODE(MODE_B)) u_out_b (
        .clk      (clk_b),
        .arst     (arst_b),
        .en       (req_b.en),
        .we       (req_b.we),
        .wdata    (req_b.data),
        .word_now (rdata_v[1]),
        .dout     (dout_b)
    );

endmodule

// File: rtl/tdp_ram_wm_chk.sv
module tdp_ram_wm_chk
    import tdp_ram_pkg::*;
#(
    parameter int       DATA_W = 9,
    parameter wr_mode_e MODE_A = WM_NORMAL,
    parameter wr_mode_e MODE_B = WM_NORMAL
) (
    input logic              clk_a,
    input logic              rst_a,
    input logic              en_a,
    input logic              we_a,
    input logic [DATA_W-1:0] din_a,
    input logic [DATA_W-1:0] dout_a,
    input logic              clk_b,
    input logic              rst_b,
    input logic              en_b,
    input logic              we_b,
    input logic [DATA_W-1:0] din_b,
    input logic [DATA_W-1:0] dout_b,
    input logic              glob_rst_n
);
    // R5: a disabled port keeps its output
    p_hold_idle_a_r5: assert property (@(posedge clk_a) disable iff (rst_a || !glob_rst_n)
        !en_a |=> $stable(dout_a));
    p_hold_idle_b_r5: assert property (@(posedge clk_b) disable iff (rst_b || !glob_rst_n)
        !en_b |=> $stable(dout_b));

    // R2: normal mode output does not move on a write
    p_norm_a_r2: assert property (@(posedge clk_a) disable iff (rst_a || !glob_rst_n)
        (MODE_A == WM_NORMAL) && en_a && we_a |=> $stable(dout_a));
    p_norm_b_r2: assert property (@(posedge clk_b) disable iff (rst_b || !glob_rst_n)
        (MODE_B == WM_NORMAL) && en_b && we_b |=> $stable(dout_b));

    // R3: write-through output echoes the write data
    p_thru_a_r3: assert property (@(posedge clk_a) disable iff (rst_a || !glob_rst_n)
        (MODE_A == WM_WRITE_THRU) && en_a && we_a |=> dout_a == $past(din_a));
    p_thru_b_r3: assert property (@(posedge clk_b) disable iff (rst_b || !glob_rst_n)
        (MODE_B == WM_WRITE_THRU) && en_b && we_b |=> dout_b == $past(din_b));

    // R6, R7, R8: outputs are zero while a reset is active
    p_clr_a_r6: assert property (@(posedge clk_a) rst_a |-> dout_a == '0);
    p_clr_b_r7: assert property (@(posedge clk_b) rst_b |-> dout_b == '0);
    p_glob_a_r8: assert property (@(posedge clk_a) !glob_rst_n |-> dout_a == '0);
    p_glob_b_r8: assert property (@(posedge clk_b) !glob_rst_n |-> dout_b == '0);

endmodule

bind tdp_ram_wm tdp_ram_wm_chk #(
    .DATA_W (DATA_W),
    .MODE_A (MODE_A),
    .MODE_B (MODE_B)
) u_chk (
    .clk_a      (clk_a),
    .rst_a      (rst_a),
    .en_a       (en_a),
    .we_a       (we_a),
    .din_a      (din_a),
    .dout_a     (dout_a),
    .clk_b      (clk_b),
    .rst_b      (rst_b),
    .en_b       (en_b),
    .we_b       (we_b),
    .din_b      (din_b),
    .dout_b     (dout_b),
    .glob_rst_n (glob_rst_n)
);

// File: tb/tdp_ram_wm_tb.sv
`timescale 1ns/1ps
module tdp_ram_wm_tb;
    import tdp_ram_pkg::*;

    localparam int AW = 6;
    localparam int DW = 9;
    localparam int NW = 8;

    logic clk = 1'b0;
    always #4 clk = ~clk;  // 125 MHz

    logic          glob_rst_n = 1'b0;
    logic          rst_a = 1'b0, rst_b = 1'b0;
    logic          en_a = 1'b0, we_a = 1'b0, en_b = 1'b0, we_b = 1'b0;
    logic [AW-1:0] addr_a = '0, addr_b = '0;
    logic [DW-1:0] din_a = '0, din_b = '0;
    logic [DW-1:0] dout_a, dout_b;

    // second instance: both ports in normal mode, 8-bit words
    logic          n_en_a = 1'b0, n_we_a = 1'b0, n_en_b = 1'b0, n_we_b = 1'b0;
    logic [AW-1:0] n_addr_a = '0, n_addr_b = '0;
    logic [NW-1:0] n_din_a = '0, n_din_b = '0;
    logic [NW-1:0] n_dout_a, n_dout_b;

    // A: read-before-write, B: write-through
    tdp_ram_wm #(.ADDR_W(AW), .DATA_W(DW), .MODE_A(WM_READ_OLD), .MODE_B(WM_WRITE_THRU)) u_dut (
        .clk_a(clk), .rst_a(rst_a), .en_a(en_a), .we_a(we_a), .addr_a(addr_a),
        .din_a(din_a), .dout_a(dout_a),
        .clk_b(clk), .rst_b(rst_b), .en_b(en_b), .we_b(we_b), .addr_b(addr_b),
        .din_b(din_b), .dout_b(dout_b),
        .glob_rst_n(glob_rst_n)
    );

    tdp_ram_wm #(.ADDR_W(AW), .DATA_W(NW), .MODE_A(WM_NORMAL), .MODE_B(WM_NORMAL)) u_dut_n (
        .clk_a(clk), .rst_a(1'b0), .en_a(n_en_a), .we_a(n_we_a), .addr_a(n_addr_a),
        .din_a(n_din_a), .dout_a(n_dout_a),
        .clk_b(clk), .rst_b(1'b0), .en_b(n_en_b), .we_b(n_we_b), .addr_b(n_addr_b),
        .din_b(n_din_b), .dout_b(n_dout_b),
        .glob_rst_n(glob_rst_n)
    );

    int n_chk = 0;
    int n_fail = 0;
    bit done = 1'b0;

    task automatic check(input string tag, input logic [DW-1:0] act, input logic [DW-1:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    typedef struct packed {
        logic          pb;    // 0 = port A, 1 = port B
        logic          en;
        logic          we;
        logic [AW-1:0] addr;
        logic [DW-1:0] din;
        logic [DW-1:0] exp;   // expected output of the driven port
        logic [3:0]    rq;    // requirement number for the message
    } vec_t;

    localparam int NVEC = 14;
    localparam vec_t VEC [NVEC] = '{
        '{1'b1, 1'b1, 1'b1, 6'd3,  9'h0A5, 9'h0A5, 4'd3},  // R3 B write-through
        '{1'b1, 1'b1, 1'b1, 6'd7,  9'h1C3, 9'h1C3, 4'd3},  // R3
        '{1'b0, 1'b1, 1'b0, 6'd3,  9'h000, 9'h0A5, 4'd10}, // R10 A reads B's word
        '{1'b0, 1'b1, 1'b1, 6'd3,  9'h155, 9'h0A5, 4'd4},  // R4 A shows old word
        '{1'b0, 1'b1, 1'b0, 6'd7,  9'h000, 9'h1C3, 4'd1},  // R1 read
        '{1'b1, 1'b1, 1'b0, 6'd3,  9'h000, 9'h155, 4'd4},  // R4 new word stored
        '{1'b0, 1'b1, 1'b1, 6'd7,  9'h00F, 9'h1C3, 4'd4},  // R4
        '{1'b1, 1'b0, 1'b1, 6'd3,  9'h111, 9'h155, 4'd5},  // R5 disabled write
        '{1'b0, 1'b1, 1'b0, 6'd3,  9'h000, 9'h155, 4'd5},  // R5 word untouched
        '{1'b1, 1'b1, 1'b1, 6'd63, 9'h1FF, 9'h1FF, 4'd3},  // R3 top address
        '{1'b0, 1'b1, 1'b1, 6'd63, 9'h000, 9'h1FF, 4'd4},  // R4 top address
        '{1'b1, 1'b1, 1'b0, 6'd63, 9'h000, 9'h000, 4'd10}, // R10
        '{1'b0, 1'b0, 1'b0, 6'd7,  9'h000, 9'h1FF, 4'd5},  // R5 disabled read
        '{1'b1, 1'b1, 1'b0, 6'd7,  9'h000, 9'h00F, 4'd1}   // R1
    };

    task automatic op(input logic pb, input logic en, input logic we,
                      input logic [AW-1:0] addr, input logic [DW-1:0] din);
        @(negedge clk);
        if (!pb) begin en_a = en; we_a = we; addr_a = addr; din_a = din; end
        else     begin en_b = en; we_b = we; addr_b = addr; din_b = din; end
        @(posedge clk);
        #1;
        en_a = 1'b0; we_a = 1'b0; en_b = 1'b0; we_b = 1'b0;
    endtask

    task automatic n_op(input logic pb, input logic we,
                        input logic [AW-1:0] addr, input logic [NW-1:0] din);
        @(negedge clk);
        if (!pb) begin n_en_a = 1'b1; n_we_a = we; n_addr_a = addr; n_din_a = din; end
        else     begin n_en_b = 1'b1; n_we_b = we; n_addr_b = addr; n_din_b = din; end
        @(posedge clk);
        #1;
        n_en_a = 1'b0; n_we_a = 1'b0; n_en_b = 1'b0; n_we_b = 1'b0;
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 8);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        // R8 reset state
        #1;
        check("R8 reset dout_a", dout_a, '0);
        check("R8 reset dout_b", dout_b, '0);
        check("R8 reset normal dout_a", {1'b0, n_dout_a}, '0);
        @(negedge clk);
        glob_rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            op(VEC[i].pb, VEC[i].en, VEC[i].we, VEC[i].addr, VEC[i].din);
            check($sformatf("R%0d vector %0d", VEC[i].rq, i),
                  VEC[i].pb ? dout_b : dout_a, VEC[i].exp);
        end
        // now dout_a = 1FF, dout_b = 00F

        // R6: port A local reset, asynchronous, A only
        @(negedge clk);
        rst_a = 1'b1;
        #1;
        check("R6 dout_a cleared", dout_a, '0);
        check("R6 dout_b kept", dout_b, 9'h00F);
        @(posedge clk);
        @(negedge clk);
        rst_a = 1'b0;

        // R7: port B local reset
        op(1'b0, 1'b1, 1'b0, 6'd3, '0);
        @(negedge clk);
        rst_b = 1'b1;
        #1;
        check("R7 dout_b cleared", dout_b, '0);
        check("R7 dout_a kept", dout_a, 9'h155);
        @(posedge clk);
        @(negedge clk);
        rst_b = 1'b0;

        // R9: contents survive local resets
        op(1'b1, 1'b1, 1'b0, 6'd7, '0);
        check("R9 word 7 after resets", dout_b, 9'h00F);

        // R2 / R1 / R10 on the normal-mode instance
        n_op(1'b0, 1'b1, 6'd1, 8'h5A);
        check("R2 normal A write holds", {1'b0, n_dout_a}, '0);
        n_op(1'b0, 1'b0, 6'd1, 8'h00);
        check("R1 normal A read", {1'b0, n_dout_a}, 9'h05A);
        n_op(1'b1, 1'b0, 6'd1, 8'h00);
        check("R10 normal B read", {1'b0, n_dout_b}, 9'h05A);
        n_op(1'b1, 1'b1, 6'd1, 8'h33);
        check("R2 normal B write holds", {1'b0, n_dout_b}, 9'h05A);
        n_op(1'b0, 1'b0, 6'd1, 8'h00);
        check("R10 normal A sees B write", {1'b0, n_dout_a}, 9'h033);

        // R8: global reset mid-run clears all outputs without a clock edge
        @(negedge clk);
        glob_rst_n = 1'b0;
        #1;
        check("R8 global dout_a", dout_a, '0);
        check("R8 global dout_b", dout_b, '0);
        check("R8 global normal dout_a", {1'b0, n_dout_a}, '0);
        @(posedge clk);
        @(negedge clk);
        glob_rst_n = 1'b1;

        // R9: contents survive the global reset
        op(1'b0, 1'b1, 1'b0, 6'd63, '0);
        check("R9 word 63 after global reset", dout_a, 9'h000);
        op(1'b0, 1'b1, 1'b0, 6'd3, '0);
        check("R9 word 3 after global reset", dout_a, 9'h155);
        n_op(1'b1, 1'b0, 6'd1, 8'h00);
        check("R9 normal word 1 after global reset", {1'b0, n_dout_b}, 9'h033);

        // R11: mode/width legality
        check("R11 old@9",   {8'd0, mode_ok(WM_READ_OLD, 9)},   9'd1);
        check("R11 old@18",  {8'd0, mode_ok(WM_READ_OLD, 18)},  9'd1);
        check("R11 old@36",  {8'd0, mode_ok(WM_READ_OLD, 36)},  9'd1);
        check("R11 old@8",   {8'd0, mode_ok(WM_READ_OLD, 8)},   9'd0);
        check("R11 old@32",  {8'd0, mode_ok(WM_READ_OLD, 32)},  9'd0);
        check("R11 thru@13", {8'd0, mode_ok(WM_WRITE_THRU, 13)}, 9'd1);
        check("R11 norm@8",  {8'd0, mode_ok(WM_NORMAL, 8)},     9'd1);

        repeat (2) @(posedge clk);
        finish_run();
    end

endmodule